// File: doc/BRIEF.md
# Memory-Type-Aware Ordered Write Buffer

This block sits between a processor load/store port and one downstream memory bus. It sorts every request by address into one of three ordering classes (Normal, Device, Strongly Ordered), plus an invalid range. From that class it decides whether the access may be posted, whether it may overtake older buffered writes, or whether it must wait for older traffic to drain first.

Writes to Normal and Device memory are posted. They enter a four-entry in-order buffer and are acknowledged at once. Reads and Strongly Ordered writes go straight to the bus as direct accesses. Each one is acknowledged in the cycle the bus response returns, and that response carries the read data and the error flag. The buffer drains one entry at a time, and only one bus transaction is ever in flight.

A barrier input holds new requests until the buffer is empty and the bus is idle. Requests whose address has no class complete at once with an error and never reach the bus.

Top module: `orderedWriteBuffer`

## Requirements
- R1: Addresses are classified as follows. 0x4000_0000–0x5FFF_FFFF is Device. 0xE000_0000–0xE00F_FFFF is Strongly Ordered. Every address below 0xE000_0000 that is not Device is Normal, including 0x6000_0000–0xDFFF_FFFF.
- R2: A request at or above 0xE010_0000 completes with `reqReady` and `rspErr` both high in the cycle it is presented, provided no barrier hold applies. It never appears on the bus.
- R3: A Normal or Device write is acknowledged (`reqReady` high) in the same cycle it is presented while the buffer has a free entry. This holds even when the bus is stalled.
- R4: Buffered writes reach the bus in acceptance order, with the address, data and strobes they were accepted with. An entry leaves the buffer only when its bus response arrives.
- R5: The buffer holds 4 entries. A posted write presented while all 4 are occupied sees `reqReady` low until an entry drains.
- R6: A Normal read whose word address (bits 31:2) matches no buffered entry is issued on the bus ahead of any buffered writes still waiting.
- R7: A Normal read whose word address matches a buffered entry is issued only after that entry has drained.
- R8: A Device read is issued only after every buffered Device write has drained. It may overtake buffered Normal writes.
- R9: A Strongly Ordered access waits until the buffer is empty. A Strongly Ordered write is never buffered; its `reqReady` comes only with its bus response.
- R10: While `barrier` is high, no new request is acknowledged until the buffer is empty and no bus transaction is outstanding.
- R11: A direct access is acknowledged in the cycle `busRspValid` is high, with `rspRdata` equal to `busRdata` and `rspErr` equal to `busErr`.
- R12: `busValid` stays high until `busReady`. No new `busValid` is raised before the response to the previous transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Upstream request present (held until reqReady) |
| reqReady | output | 1 | Request completes this cycle; response fields valid |
| reqAddr | input | 32 | Byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| reqStrb | input | DATA_W/8 | Byte strobes |
| rspRdata | output | DATA_W | Read data, valid with reqReady |
| rspErr | output | 1 | Error, valid with reqReady |
| barrier | input | 1 | Hold new requests until all traffic drains |
| busValid | output | 1 | Downstream request valid |
| busReady | input | 1 | Downstream accepts request |
| busAddr | output | 32 | Downstream address |
| busWrite | output | 1 | Downstream write flag |
| busWdata | output | DATA_W | Downstream write data |
| busStrb | output | DATA_W/8 | Downstream byte strobes |
| busRspValid | input | 1 | Downstream response (one cycle) |
| busRdata | input | DATA_W | Downstream read data |
| busErr | input | 1 | Downstream error |

## Verification
The bench targets the points where ordering can silently go wrong. It checks that a read to a word still sitting in the buffer does not overtake the write to that word, which would return stale data. It checks that a Device read leaves an older Device write ahead of it yet passes a younger Normal write; a design that ignored class would either deadlock traffic or reorder peripheral accesses. It checks that a Strongly Ordered write is acknowledged only after it has reached the bus, not on being posted, and that it follows every older buffered write. It also covers the full-buffer stall while the bus is blocked and the barrier hold. A design with a wrong range decode shows up in the invalid, upper Normal and private-bus ranges, either as a write posted when it should not be or as an error where none belongs.

// File: rtl/owbPkg.sv
package owbPkg;

  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    MT_NORMAL  = 2'd0,
    MT_DEVICE  = 2'd1,
    MT_STRONG  = 2'd2,
    MT_INVALID = 2'd3
  } memType_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;    // store upstream write into the buffer
    logic pop;     // retire the head entry
    logic selDir;  // bus carries the upstream request, not the buffer head
  } owbCtl_t;

  function automatic memType_t classifyAddr(input logic [ADDR_W-1:0] addr);
    if (addr[31:20] >= 12'hE01)      return MT_INVALID;
    else if (addr[31:20] == 12'hE00) return MT_STRONG;
    else if (addr[31:29] == 3'b010)  return MT_DEVICE;
    else                             return MT_NORMAL;
  endfunction

endpackage

// File: rtl/owbDatapath.sv
module owbDatapath
  import owbPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  owbCtl_t               ctl,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqStrb,
  output logic                  full,
  output logic                  empty,
  output logic                  hitWord,
  output logic                  anyDev,
  output logic [ADDR_W-1:0]     busAddr,
  output logic                  busWrite,
  output logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W/8-1:0]   busStrb
);

  localparam int STRB_W = DATA_W / 8;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [STRB_W-1:0] entStrb [DEPTH];
  logic [DEPTH-1:0]  entDev;
  logic [DEPTH-1:0]  entValid;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DEPTH-1:0]  hitVec, devVec;
  logic              reqIsDev;

  assign reqIsDev = (classifyAddr(reqAddr) == MT_DEVICE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else begin
      if (ctl.push) begin
        entValid[wrPtr] <= 1'b1;
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (ctl.pop) begin
        entValid[rdPtr] <= 1'b0;
        rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      entAddr[wrPtr] <= reqAddr;
      entData[wrPtr] <= reqWdata;
      entStrb[wrPtr] <= reqStrb;
      entDev[wrPtr]  <= reqIsDev;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    assign hitVec[g] = entValid[g] && (entAddr[g][ADDR_W-1:2] == reqAddr[ADDR_W-1:2]);
    assign devVec[g] = entValid[g] && entDev[g];
  end

  assign full    = entValid[wrPtr];
  assign empty   = !entValid[rdPtr];
  assign hitWord = |hitVec;
  assign anyDev  = |devVec;

  assign busAddr  = ctl.selDir ? reqAddr  : entAddr[rdPtr];
  assign busWrite = ctl.selDir ? reqWrite : 1'b1;
  assign busWdata = ctl.selDir ? reqWdata : entData[rdPtr];
  assign busStrb  = ctl.selDir ? reqStrb  : entStrb[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> !full); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> !empty); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !ctl.pop) |=> full); // R5

endmodule

// File: rtl/owbControl.sv
module owbControl
  import owbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              barrier,
  input  logic              full,
  input  logic              empty,
  input  logic              hitWord,
  input  logic              anyDev,
  input  logic              busReady,
  input  logic              busRspValid,
  input  logic              busErr,
  output owbCtl_t           ctl,
  output logic              reqReady,
  output logic              rspErr,
  output logic              busValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} busState_t;

  busState_t state, stateNxt;
  logic      selDir, selDirNxt;
  memType_t  cls;
  logic      hold, wantPost, postOk, errOk, dirOk, dirDone, orderOk;

  assign cls      = classifyAddr(reqAddr);
  assign hold     = barrier && !(empty && state == ST_IDLE);
  assign wantPost = reqWrite && (cls == MT_NORMAL || cls == MT_DEVICE);

  always_comb begin
    unique case (cls)
      MT_NORMAL: orderOk = !hitWord;
      MT_DEVICE: orderOk = !anyDev;
      default:   orderOk = empty;
    endcase
  end

  assign postOk  = reqValid && !hold && wantPost && !full;
  assign errOk   = reqValid && !hold && cls == MT_INVALID;
  assign dirOk   = reqValid && !hold && !wantPost && cls != MT_INVALID && orderOk;
  assign dirDone = state == ST_WAIT && selDir && busRspValid;

  always_comb begin
    stateNxt  = state;
    selDirNxt = selDir;
    unique case (state)
      ST_IDLE: begin
        if (dirOk) begin
          stateNxt  = ST_REQ;
          selDirNxt = 1'b1;
        end else if (!empty) begin
          stateNxt  = ST_REQ;
          selDirNxt = 1'b0;
        end
      end
      ST_REQ:  if (busReady) stateNxt = ST_WAIT;
      ST_WAIT: if (busRspValid) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      selDir <= 1'b0;
    end else begin
      state  <= stateNxt;
      selDir <= selDirNxt;
    end
  end

  assign ctl.push   = postOk;
  assign ctl.pop    = state == ST_WAIT && !selDir && busRspValid;
  assign ctl.selDir = selDir;
  assign busValid   = state == ST_REQ;
  assign reqReady   = postOk || errOk || dirDone;
  assign rspErr     = errOk || (dirDone && busErr);

  AST_SO_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && selDir && cls == MT_STRONG) |-> empty); // R9
  AST_DEV_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && selDir && cls == MT_DEVICE) |-> !anyDev); // R8
  AST_HIT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && selDir && cls == MT_NORMAL) |-> !hitWord); // R7
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cls == MT_INVALID) |-> !(busValid && selDir)); // R2
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busValid); // R12
  AST_BARRIER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (barrier && !empty && !(state == ST_WAIT && selDir)) |-> !reqReady); // R10

endmodule

// File: rtl/orderedWriteBuffer.sv
module orderedWriteBuffer
  import owbPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [31:0]         reqAddr,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqStrb,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                rspErr,
  input  logic                barrier,
  output logic                busValid,
  input  logic                busReady,
  output logic [31:0]         busAddr,
  output logic                busWrite,
  output logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W/8-1:0] busStrb,
  input  logic                busRspValid,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busErr
);

  owbCtl_t ctl;
  logic    full, empty, hitWord, anyDev;

  owbControl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .barrier(barrier), .full(full), .empty(empty),
    .hitWord(hitWord), .anyDev(anyDev), .busReady(busReady),
    .busRspValid(busRspValid), .busErr(busErr), .ctl(ctl),
    .reqReady(reqReady), .rspErr(rspErr), .busValid(busValid)
  );

  owbDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqStrb(reqStrb),
    .full(full), .empty(empty), .hitWord(hitWord), .anyDev(anyDev),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .busStrb(busStrb)
  );

  assign rspRdata = busRdata;

endmodule

// File: tb/test_orderedWriteBuffer.sv
`timescale 1ns/100ps
module test_orderedWriteBuffer;

  localparam logic [31:0] MAGIC = 32'hA5A5_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, barrier = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [3:0]  reqStrb = 4'hF;
  logic        reqReady, rspErr, busValid, busWrite;
  logic [31:0] rspRdata, busAddr, busWdata;
  logic [3:0]  busStrb;
  logic        busReady;
  logic        busRspValid = 1'b0, busErr = 1'b0;
  logic [31:0] busRdata = '0;

  int tests = 0, fails = 0;
  bit done = 0;
  bit busHold = 0;
  int busLat = 3;
  int logCnt = 0;
  int protoErr = 0;
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic        logWr   [64];
  bit          pending = 0;
  int          cnt = 0;
  logic [31:0] pendAddr = '0;

  always #2.5 clk = ~clk;
  assign busReady = !busHold;

  orderedWriteBuffer i_orderedWriteBuffer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqStrb(reqStrb), .rspRdata(rspRdata), .rspErr(rspErr),
    .barrier(barrier), .busValid(busValid), .busReady(busReady),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .busStrb(busStrb), .busRspValid(busRspValid), .busRdata(busRdata),
    .busErr(busErr)
  );

  // downstream bus model: single outstanding, fixed latency
  always @(posedge clk) begin
    busRspValid <= 1'b0;
    if (rstN) begin
      if (pending) begin
        if (busValid) protoErr++;            // R12
        if (cnt <= 1) begin
          busRspValid <= 1'b1;
          busRdata    <= pendAddr ^ MAGIC;
          pending     <= 0;
        end else cnt <= cnt - 1;
      end else if (busValid && busReady) begin
        if (logCnt < 64) begin
          logAddr[logCnt] = busAddr;
          logData[logCnt] = busWdata;
          logWr[logCnt]   = busWrite;
        end
        logCnt++;
        pending  <= 1;
        cnt      <= busLat;
        pendAddr <= busAddr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic access(input logic [31:0] a, input bit w, input logic [31:0] d,
                        output logic [31:0] rd, output bit er, output int waited);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqWrite = w; reqWdata = d; reqStrb = 4'hF;
    waited = 0;
    forever begin
      #1;
      if (reqReady) break;
      @(negedge clk);
      waited++;
      if (waited > 2000) break;
    end
    rd = rspRdata; er = rspErr;
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
    logCnt = 0;
  endtask

  task automatic testReset();
    #1;
    check(busValid === 1'b0, "R12", $sformatf("busValid after reset act=%b exp 0", busValid));
    check(reqReady === 1'b0, "R3", $sformatf("reqReady idle act=%b exp 0", reqReady));
  endtask

  task automatic testError();
    logic [31:0] rd; bit er; int w;
    access(32'hE010_0000, 0, 0, rd, er, w);
    check(er && w == 0, "R2", $sformatf("err=%b wait=%0d exp 1/0", er, w));
    access(32'hFFFF_FFFC, 1, 32'h1, rd, er, w);
    check(er && w == 0, "R2", $sformatf("err=%b wait=%0d exp 1/0", er, w));
    repeat (10) @(negedge clk);
    check(logCnt == 0, "R2", $sformatf("bus txns act=%0d exp 0", logCnt));
    settle();
  endtask

  task automatic testFull();
    logic [31:0] rd; bit er; int w;
    bit stalled;
    busHold = 1;
    for (int i = 0; i < 4; i++) begin
      access(32'h2000_0000 + 32'(i*4) + (i == 1 ? 32'h2000_0000 : 0), 1, 32'h100 + 32'(i), rd, er, w);
      check(w == 0, "R3", $sformatf("posted write %0d wait act=%0d exp 0", i, w));
    end
    @(negedge clk);
    reqValid = 1; reqAddr = 32'h2000_0080; reqWrite = 1; reqWdata = 32'h104;
    stalled = 1;
    repeat (3) begin @(negedge clk); #1; if (reqReady) stalled = 0; end
    check(stalled, "R5", "fifth write accepted while buffer full, exp stall");
    busHold = 0;
    w = 0;
    forever begin #1; if (reqReady || w > 500) break; @(negedge clk); w++; end
    @(posedge clk); #1; reqValid = 0;
    repeat (60) @(negedge clk);
    check(logCnt == 5, "R4", $sformatf("drained act=%0d exp 5", logCnt));
    for (int i = 0; i < 5; i++) begin
      logic [31:0] ea;
      ea = (i == 4) ? 32'h2000_0080 : 32'h2000_0000 + 32'(i*4) + (i == 1 ? 32'h2000_0000 : 0);
      check(logAddr[i] == ea && logData[i] == 32'h100 + 32'(i) && logWr[i], "R4",
            $sformatf("entry %0d addr %h data %h exp %h %h", i, logAddr[i], logData[i], ea, 32'h100 + 32'(i)));
    end
    settle();
  endtask

  task automatic testBypass();
    logic [31:0] rd; bit er; int w;
    access(32'h2000_0010, 1, 32'hA, rd, er, w);
    access(32'h2000_0020, 1, 32'hB, rd, er, w);
    access(32'h2000_0100, 0, 0, rd, er, w);
    check(rd == (32'h2000_0100 ^ MAGIC) && !er, "R11", $sformatf("rdata act=%h exp %h", rd, 32'h2000_0100 ^ MAGIC));
    repeat (40) @(negedge clk);
    check(logCnt == 3 && logAddr[1] == 32'h2000_0100 && !logWr[1] && logAddr[2] == 32'h2000_0020, "R6",
          $sformatf("order act=%h,%h exp read then %h", logAddr[1], logAddr[2], 32'h2000_0020));
    settle();
  endtask

  task automatic testHit();
    logic [31:0] rd; bit er; int w;
    access(32'h2000_0040, 1, 32'hC, rd, er, w);
    access(32'h2000_0050, 1, 32'hD, rd, er, w);
    access(32'h2000_0052, 0, 0, rd, er, w);
    repeat (40) @(negedge clk);
    check(logCnt == 3 && logAddr[1] == 32'h2000_0050 && logWr[1] && !logWr[2], "R7",
          $sformatf("read passed matching write: slot1 %h wr=%b", logAddr[1], logWr[1]));
    check(rd == (32'h2000_0052 ^ MAGIC), "R11", $sformatf("rdata act=%h exp %h", rd, 32'h2000_0052 ^ MAGIC));
    settle();
  endtask

  task automatic testDevice();
    logic [31:0] rd; bit er; int w;
    access(32'h2000_0200, 1, 32'h1, rd, er, w);
    access(32'h4000_0010, 1, 32'h2, rd, er, w);
    check(w == 0, "R3", $sformatf("device write wait act=%0d exp 0", w));
    access(32'h2000_0204, 1, 32'h3, rd, er, w);
    access(32'h5FFF_FFFC, 0, 0, rd, er, w);
    repeat (40) @(negedge clk);
    check(logCnt == 4 && logAddr[1] == 32'h4000_0010 && logAddr[2] == 32'h5FFF_FFFC && !logWr[2]
          && logAddr[3] == 32'h2000_0204, "R8",
          $sformatf("order %h,%h,%h exp dev write, dev read, normal", logAddr[1], logAddr[2], logAddr[3]));
    settle();
  endtask

  task automatic testStrong();
    logic [31:0] rd; bit er; int w;
    access(32'h2000_0300, 1, 32'h5, rd, er, w);
    access(32'hE000_E010, 1, 32'h6, rd, er, w);
    check(w >= busLat, "R9", $sformatf("SO write ack wait act=%0d exp >= %0d", w, busLat));
    check(logCnt == 2 && logAddr[1] == 32'hE000_E010 && logWr[1], "R9",
          $sformatf("SO on bus at ack: count %0d addr %h", logCnt, logAddr[1]));
    check(logAddr[0] == 32'h2000_0300, "R9", $sformatf("older write first act=%h", logAddr[0]));
    access(32'hE00F_FFFC, 1, 32'h7, rd, er, w);
    check(w >= busLat && !er, "R1", $sformatf("top of SO range wait=%0d err=%b", w, er));
    settle();
  endtask

  task automatic testRanges();
    logic [31:0] rd; bit er; int w;
    access(32'h6000_0000, 1, 32'h8, rd, er, w);
    check(w == 0 && !er, "R1", $sformatf("0x6000_0000 posted wait=%0d err=%b", w, er));
    access(32'hD000_0000, 1, 32'h9, rd, er, w);
    check(w == 0 && !er, "R1", $sformatf("0xD000_0000 posted wait=%0d err=%b", w, er));
    access(32'hDFFF_FFFC, 0, 0, rd, er, w);
    check(!er && rd == (32'hDFFF_FFFC ^ MAGIC), "R1", $sformatf("upper normal read %h err=%b", rd, er));
    settle();
  endtask

  task automatic testBarrier();
    logic [31:0] rd; bit er; int w;
    access(32'h2000_0400, 1, 32'hE, rd, er, w);
    barrier = 1;
    access(32'h2000_0500, 1, 32'hF, rd, er, w);
    check(w >= busLat, "R10", $sformatf("write under barrier wait act=%0d exp >= %0d", w, busLat));
    barrier = 0;
    repeat (30) @(negedge clk);
    check(logCnt == 2 && logAddr[1] == 32'h2000_0500, "R10", $sformatf("txns %0d", logCnt));
    settle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (2) @(negedge clk);
    testError();
    testFull();
    testBypass();
    testHit();
    testDevice();
    testStrong();
    testRanges();
    testBarrier();
    check(protoErr == 0, "R12", $sformatf("overlapping bus requests act=%0d exp 0", protoErr));
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run hung, act=timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule